// File: doc/BRIEF.md
# Handshaked Serial Transceiver with Optional Parity

This block is a full-duplex serial link endpoint for parallel words, 8 bits by default. It has no baud divider. Every serial bit lasts exactly one system clock, and bits travel most significant first. A frame is a low start bit, the data bits, an optional even-parity bit, and a high stop bit. A compile-time parameter decides whether the parity bit is present.

The transmit side is gated by a request/clear handshake. The remote requester raises RTS, and the block answers with CTS one clock later. A one-cycle send strobe is taken only while CTS is high and the transmitter is ready. The receive side watches rx for a start bit and shifts the frame in. After a complete frame it raises a ready flag. A read strobe then moves the byte and its error flag to the outputs. The error flag reports a parity mismatch, a low stop bit, or a frame that overwrote an unread one.

The reset input is asynchronous and active low. Its release is synchronised inside the block, so the internal logic leaves reset two clocks after `rst_ni` rises.

Top module: `hs_serial_xcvr`

## Requirements
- R1: After reset, tx is 1, tx_ready is 1, rx_ready is 0, cts is 0, and rx_data and rx_err are 0.
- R2: cts equals the value rts had at the previous clock edge.
- R3: A send is taken at a clock edge only when send, cts and tx_ready are all 1 there. tx then carries the start bit 0 for the following cycle.
- R4: Each frame bit lasts one clock. The data bits follow the start bit most significant bit first, so 8'hAA gives 1,0,1,0,1,0,1,0.
- R5: With PAR_EN=1, an even-parity bit (the XOR of all data bits) follows the last data bit and comes before a stop bit of 1. With PAR_EN=0, the stop bit follows the last data bit directly.
- R6: tx_ready is 0 from the start bit through the parity bit. It is 1 during the stop bit and in idle. A send taken during the stop bit starts the next start bit right after it, with no idle cycle.
- R7: A 0 on rx while the receiver is idle is a start bit. The data bits (MSB first), the parity bit when enabled, and the stop bit are then sampled one per clock. rx_ready is 1 in the cycle after the stop bit is sampled.
- R8: A read strobe with rx_ready 1 loads rx_data with the byte and rx_err with its flag for the next cycle, and clears rx_ready unless another frame completes at that edge. A read while rx_ready is 0 leaves rx_data and rx_err unchanged.
- R9: A frame's error flag is 1 when its stop bit is sampled as 0, or, with PAR_EN=1, when its parity bit differs from the XOR of its data bits. The flag holds until the next read.
- R10: A frame that completes while rx_ready is 1, with no read at that edge, replaces the stored byte and carries an error flag of 1.
- R11: A send while cts is 0, or while tx_ready is 0, is ignored. The frame in progress goes on unchanged, and an idle line stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; one serial bit per cycle |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tx_data_i | input | DATA_W | Word to transmit, sampled on an accepted send |
| send_i | input | 1 | Send strobe |
| tx_ready_o | output | 1 | Transmitter can take a word |
| tx_o | output | 1 | Serial output line |
| rts_i | input | 1 | Request to send from the remote side |
| cts_o | output | 1 | Clear to send answer |
| rx_i | input | 1 | Serial input line |
| rx_data_o | output | DATA_W | Last word read out |
| rx_ready_o | output | 1 | A received word is waiting |
| rx_err_o | output | 1 | Error flag of the last word read out |
| read_i | input | 1 | Read strobe |

## Verification
The bench builds two copies of the block side by side, one with PAR_EN=1 and one with PAR_EN=0, both 8 bits wide. Together they cover both frame lengths (11 and 10 clocks). They show how back-to-back frames line up on the stop bit for each length. The parity-mismatch error is only reachable in the PAR_EN=1 copy. In the PAR_EN=0 copy, a corrupted parity position is simply the stop bit, or idle, and must not raise an error on its own.

// File: rtl/hsx_pkg.sv
package hsx_pkg;

  typedef enum logic [2:0] {
    TXS_IDLE  = 3'd0,
    TXS_START = 3'd1,
    TXS_DATA  = 3'd2,
    TXS_PAR   = 3'd3,
    TXS_STOP  = 3'd4
  } tx_state_e;

  typedef enum logic [1:0] {
    RXS_IDLE = 2'd0,
    RXS_DATA = 2'd1,
    RXS_PAR  = 2'd2,
    RXS_STOP = 2'd3
  } rx_state_e;

endpackage

// File: rtl/hsx_rst_sync.sv
module hsx_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_no = sync_q[1];

endmodule

// File: rtl/hsx_flow.sv
module hsx_flow (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rts_i,
  output logic cts_o
);

  logic cts_q, cts_d;

  always_comb begin
    cts_d = rts_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cts_q <= 1'b0;
    end else begin
      cts_q <= cts_d;
    end
  end

  assign cts_o = cts_q;

  AST_CTS_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rts_i |=> cts_o);  // R2
  AST_CTS_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rts_i |=> !cts_o);  // R2

endmodule

// File: rtl/hsx_tx.sv
module hsx_tx
  import hsx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter bit PAR_EN = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              send_i,
  input  logic              cts_i,
  output logic              tx_o,
  output logic              ready_o
);

  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_W - 1);

  tx_state_e          st_q, st_d;
  tx_state_e          post_data_st;
  logic [DATA_W-1:0]  sh_q, sh_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               par_q, par_d;
  logic               par_load;
  logic               accept;
  logic               reg_en;

  generate
    if (PAR_EN) begin : g_par
      assign post_data_st = TXS_PAR;
      assign par_load     = ^data_i;
    end else begin : g_nopar
      assign post_data_st = TXS_STOP;
      assign par_load     = 1'b0;
    end
  endgenerate

  assign ready_o = (st_q == TXS_IDLE) || (st_q == TXS_STOP);
  assign accept  = send_i & cts_i & ready_o;
  assign reg_en  = accept | (st_q != TXS_IDLE);

  always_comb begin
    st_d  = st_q;
    sh_d  = sh_q;
    cnt_d = cnt_q;
    par_d = par_q;
    unique case (st_q)
      TXS_IDLE: begin
        st_d = TXS_IDLE;
      end
      TXS_START: begin
        st_d  = TXS_DATA;
        cnt_d = '0;
      end
      TXS_DATA: begin
        sh_d  = {sh_q[DATA_W-2:0], 1'b0};
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == LAST_IDX) begin
          st_d = post_data_st;
        end
      end
      TXS_PAR: begin
        st_d = TXS_STOP;
      end
      TXS_STOP: begin
        st_d = TXS_IDLE;
      end
      default: begin
        st_d = TXS_IDLE;
      end
    endcase
    if (accept) begin
      st_d  = TXS_START;
      sh_d  = data_i;
      par_d = par_load;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= TXS_IDLE;
      sh_q  <= '0;
      cnt_q <= '0;
      par_q <= 1'b0;
    end else if (reg_en) begin
      st_q  <= st_d;
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
      par_q <= par_d;
    end
  end

  always_comb begin
    unique case (st_q)
      TXS_START: tx_o = 1'b0;
      TXS_DATA:  tx_o = sh_q[DATA_W-1];
      TXS_PAR:   tx_o = par_q;
      default:   tx_o = 1'b1;
    endcase
  end

  AST_START_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> (!tx_o && !ready_o));  // R3
  AST_READY_ON_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> tx_o);  // R6
  AST_SEND_NO_CTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (send_i && !cts_i && ready_o) |=> (tx_o && ready_o));  // R11

endmodule

// File: rtl/hsx_rx.sv
module hsx_rx
  import hsx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter bit PAR_EN = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_i,
  input  logic              read_i,
  output logic [DATA_W-1:0] data_o,
  output logic              ready_o,
  output logic              err_o
);

  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_W - 1);

  rx_state_e          st_q, st_d;
  rx_state_e          post_data_st;
  logic [DATA_W-1:0]  sh_q, sh_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               pbit_q, pbit_d;
  logic               frame_en;

  logic [DATA_W-1:0]  hold_q, hold_d;
  logic               herr_q, herr_d;
  logic               rdy_q, rdy_d;
  logic [DATA_W-1:0]  dout_q, dout_d;
  logic               derr_q, derr_d;
  logic               out_en;

  logic               done;
  logic               par_bad;
  logic               frame_bad;
  logic               rd;

  generate
    if (PAR_EN) begin : g_par
      assign post_data_st = RXS_PAR;
      assign par_bad      = pbit_q ^ (^sh_q);
    end else begin : g_nopar
      assign post_data_st = RXS_STOP;
      assign par_bad      = 1'b0;
    end
  endgenerate

  assign done      = (st_q == RXS_STOP);
  assign frame_bad = par_bad | ~rx_i;
  assign rd        = read_i & rdy_q;
  assign frame_en  = (st_q != RXS_IDLE) | ~rx_i;
  assign out_en    = done | rd;

  // Frame capture
  always_comb begin
    st_d   = st_q;
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    pbit_d = pbit_q;
    unique case (st_q)
      RXS_IDLE: begin
        if (!rx_i) begin
          st_d  = RXS_DATA;
          cnt_d = '0;
        end
      end
      RXS_DATA: begin
        sh_d  = {sh_q[DATA_W-2:0], rx_i};
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == LAST_IDX) begin
          st_d = post_data_st;
        end
      end
      RXS_PAR: begin
        pbit_d = rx_i;
        st_d   = RXS_STOP;
      end
      RXS_STOP: begin
        st_d = RXS_IDLE;
      end
      default: begin
        st_d = RXS_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= RXS_IDLE;
      sh_q   <= '0;
      cnt_q  <= '0;
      pbit_q <= 1'b0;
    end else if (frame_en) begin
      st_q   <= st_d;
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      pbit_q <= pbit_d;
    end
  end

  // Holding stage and read-out
  always_comb begin
    hold_d = hold_q;
    herr_d = herr_q;
    dout_d = dout_q;
    derr_d = derr_q;
    rdy_d  = rdy_q & ~rd;
    if (rd) begin
      dout_d = hold_q;
      derr_d = herr_q;
    end
    if (done) begin
      hold_d = sh_q;
      herr_d = frame_bad | (rdy_q & ~read_i);
      rdy_d  = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      herr_q <= 1'b0;
      rdy_q  <= 1'b0;
      dout_q <= '0;
      derr_q <= 1'b0;
    end else if (out_en) begin
      hold_q <= hold_d;
      herr_q <= herr_d;
      rdy_q  <= rdy_d;
      dout_q <= dout_d;
      derr_q <= derr_d;
    end
  end

  assign data_o  = dout_q;
  assign err_o   = derr_q;
  assign ready_o = rdy_q;

  AST_READY_AFTER_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> ready_o);  // R7
  AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (read_i && ready_o && !done) |=> !ready_o);  // R8
  AST_IDLE_READ_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o) |=> ($stable(data_o) && $stable(err_o)));  // R8
  AST_OVERRUN_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && ready_o && !read_i) |=> (ready_o && herr_q));  // R10
  AST_STOP_LOW_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && !rx_i) |=> herr_q);  // R9

endmodule

// File: rtl/hs_serial_xcvr.sv
module hs_serial_xcvr #(
  parameter int DATA_W = 8,
  parameter bit PAR_EN = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              send_i,
  output logic              tx_ready_o,
  output logic              tx_o,
  input  logic              rts_i,
  output logic              cts_o,
  input  logic              rx_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_ready_o,
  output logic              rx_err_o,
  input  logic              read_i
);

  logic rst_n;

  hsx_rst_sync u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n)
  );

  hsx_flow u_flow (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .rts_i  (rts_i),
    .cts_o  (cts_o)
  );

  hsx_tx #(
    .DATA_W (DATA_W),
    .PAR_EN (PAR_EN)
  ) u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .data_i  (tx_data_i),
    .send_i  (send_i),
    .cts_i   (cts_o),
    .tx_o    (tx_o),
    .ready_o (tx_ready_o)
  );

  hsx_rx #(
    .DATA_W (DATA_W),
    .PAR_EN (PAR_EN)
  ) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .rx_i    (rx_i),
    .read_i  (read_i),
    .data_o  (rx_data_o),
    .ready_o (rx_ready_o),
    .err_o   (rx_err_o)
  );

endmodule

// File: tb/xcvr_harness.sv
module xcvr_harness #(
  parameter bit PAR = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] tx_data,
  input  logic       send,
  input  logic       read,
  input  logic       rts,
  input  logic       rx,
  output logic       tx,
  output logic       tx_ready,
  output logic       cts,
  output logic       rx_ready,
  output logic [7:0] rx_data,
  output logic       rx_err,
  output int         n_chk,
  output int         n_bad
);

  hs_serial_xcvr #(.DATA_W(8), .PAR_EN(PAR)) i_hs_serial_xcvr (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .tx_data_i  (tx_data),
    .send_i     (send),
    .tx_ready_o (tx_ready),
    .tx_o       (tx),
    .rts_i      (rts),
    .cts_o      (cts),
    .rx_i       (rx),
    .rx_data_o  (rx_data),
    .rx_ready_o (rx_ready),
    .rx_err_o   (rx_err),
    .read_i     (read)
  );

  // Behavioural reference: bit queues, no state machines
  bit       m_txq[$];
  bit       m_rxq[$];
  bit       m_cts, m_busy, m_ready, m_herr, m_derr;
  bit [7:0] m_hold, m_dout;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_txq.delete(); m_rxq.delete();
      m_cts = 0; m_busy = 0; m_ready = 0; m_herr = 0; m_derr = 0;
      m_hold = 0; m_dout = 0;
    end else begin
      bit acc, rd, fin, perr, serr, ov;
      bit [7:0] d;
      acc = send && m_cts && (m_txq.size() <= 1);
      if (m_txq.size() > 0) void'(m_txq.pop_front());
      if (acc) begin
        m_txq.delete();
        m_txq.push_back(1'b0);
        for (int i = 7; i >= 0; i--) m_txq.push_back(tx_data[i]);
        if (PAR) m_txq.push_back(^tx_data);
        m_txq.push_back(1'b1);
      end
      m_cts = rts;
      rd = read && m_ready;
      fin = 0; perr = 0; serr = 0; d = 0;
      if (m_busy) begin
        m_rxq.push_back(rx);
        if (m_rxq.size() == 9 + int'(PAR)) begin
          for (int i = 0; i < 8; i++) d[7-i] = m_rxq[i];
          perr = PAR && (m_rxq[8] != ^d);
          serr = !m_rxq[m_rxq.size()-1];
          fin = 1; m_busy = 0; m_rxq.delete();
        end
      end else if (!rx) begin
        m_busy = 1;
      end
      ov = m_ready && !rd;
      if (rd) begin
        m_dout = m_hold; m_derr = m_herr; m_ready = 0;
      end
      if (fin) begin
        m_hold = d; m_herr = perr | serr | ov; m_ready = 1;
      end
    end
  end

  task automatic cmp(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s (PAR=%0d) t=%0t act=%0h exp=%0h", tag, PAR, $time, act, exp);
    end
  endtask

  initial begin n_chk = 0; n_bad = 0; end

  always @(negedge clk) begin
    if (rst_n) begin
      cmp("R4 tx line", int'(tx), (m_txq.size() == 0) ? 1 : int'(m_txq[0]));
      cmp("R6 tx_ready", int'(tx_ready), (m_txq.size() <= 1) ? 1 : 0);
      cmp("R2 cts", int'(cts), int'(m_cts));
      cmp("R7 rx_ready", int'(rx_ready), int'(m_ready));
      cmp("R8 rx_data", int'(rx_data), int'(m_dout));
      cmp("R9 rx_err", int'(rx_err), int'(m_derr));
    end
  end

endmodule

// File: tb/test_hs_serial_xcvr.sv
module test_hs_serial_xcvr;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] tx_data;
  logic       send, read, rts, rx_p, rx_n;
  logic       p_tx, p_trdy, p_cts, p_rrdy, p_err;
  logic       n_tx, n_trdy, n_cts, n_rrdy, n_err;
  logic [7:0] p_dat, n_dat;
  int         p_chk, p_bad, n_chk, n_bad;
  int         total = 0;
  int         bad = 0;

  always #2 clk = ~clk;  // 250 MHz

  xcvr_harness #(.PAR(1'b1)) h_par (
    .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .send(send), .read(read),
    .rts(rts), .rx(rx_p), .tx(p_tx), .tx_ready(p_trdy), .cts(p_cts),
    .rx_ready(p_rrdy), .rx_data(p_dat), .rx_err(p_err),
    .n_chk(p_chk), .n_bad(p_bad));

  xcvr_harness #(.PAR(1'b0)) h_pln (
    .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .send(send), .read(read),
    .rts(rts), .rx(rx_n), .tx(n_tx), .tx_ready(n_trdy), .cts(n_cts),
    .rx_ready(n_rrdy), .rx_data(n_dat), .rx_err(n_err),
    .n_chk(n_chk), .n_bad(n_bad));

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s t=%0t act=%0h exp=%0h", tag, $time, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic bit fbit(input bit [7:0] d, input bit par, input int k);
    if (k == 0) return 1'b0;
    if (k <= 8) return d[8-k];
    if (par && k == 9) return ^d;
    return 1'b1;
  endfunction

  function automatic bit rbit(input bit [7:0] d, input bit par, input int k,
                              input bit bp, input bit bs);
    if (k == 0) return 1'b0;
    if (k <= 8) return d[8-k];
    if (par && k == 9) return (^d) ^ bp;
    if (k == 9 + int'(par)) return !bs;
    return 1'b1;
  endfunction

  task automatic summary();
    total += p_chk + n_chk;
    bad   += p_bad + n_bad;
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  task automatic run_frame(input bit [7:0] d, input bit inject);
    tx_data = d; send = 1'b1;
    tick();
    send = 1'b0;
    for (int k = 0; k < 12; k++) begin
      chk("R3 R4 R5 tx par", int'(p_tx), int'(fbit(d, 1'b1, k)));
      chk("R3 R4 R5 tx plain", int'(n_tx), int'(fbit(d, 1'b0, k)));
      chk("R6 ready par", int'(p_trdy), (k >= 10) ? 1 : 0);
      chk("R6 ready plain", int'(n_trdy), (k >= 9) ? 1 : 0);
      if (inject && k == 2) begin tx_data = 8'hFF; send = 1'b1; end  // R11 busy
      if (inject && k == 3) send = 1'b0;
      tick();
    end
  endtask

  task automatic put_rx(input bit [7:0] d, input bit bp, input bit bs);
    for (int k = 0; k < 12; k++) begin
      tick();
      rx_p = rbit(d, 1'b1, k, bp, bs);
      rx_n = rbit(d, 1'b0, k, bp, bs);
    end
    tick();
  endtask

  task automatic do_read(input bit [7:0] d, input bit ep, input bit en);
    read = 1'b1;
    tick();
    read = 1'b0;
    chk("R8 data par", int'(p_dat), int'(d));
    chk("R8 data plain", int'(n_dat), int'(d));
    chk("R9 err par", int'(p_err), int'(ep));
    chk("R9 err plain", int'(n_err), int'(en));
    chk("R8 ready cleared par", int'(p_rrdy), 0);
    chk("R8 ready cleared plain", int'(n_rrdy), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; tx_data = 8'h00; send = 1'b0; read = 1'b0;
    rts = 1'b0; rx_p = 1'b1; rx_n = 1'b1;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();

    // R1 reset state
    chk("R1 tx", int'(p_tx & n_tx), 1);
    chk("R1 tx_ready", int'(p_trdy & n_trdy), 1);
    chk("R1 rx_ready", int'(p_rrdy | n_rrdy), 0);
    chk("R1 cts", int'(p_cts | n_cts), 0);
    chk("R1 rx_err", int'(p_err | n_err), 0);

    // R11: send with cts low is ignored
    tx_data = 8'hA5; send = 1'b1;
    tick();
    send = 1'b0;
    chk("R11 tx idle par", int'(p_tx), 1);
    chk("R11 tx idle plain", int'(n_tx), 1);
    chk("R11 ready par", int'(p_trdy), 1);
    repeat (3) tick();
    chk("R11 still idle", int'(p_tx & n_tx), 1);

    // R2: cts follows rts one clock later
    rts = 1'b1;
    chk("R2 cts not yet", int'(p_cts | n_cts), 0);
    tick();
    chk("R2 cts par", int'(p_cts), 1);
    chk("R2 cts plain", int'(n_cts), 1);

    run_frame(8'hAA, 1'b0);
    run_frame(8'h3C, 1'b1);
    run_frame(8'h01, 1'b0);

    // R6 back to back, send held high
    tx_data = 8'h81; send = 1'b1;
    tick();
    for (int k = 0; k < 22; k++) begin
      chk("R6 b2b tx par", int'(p_tx), int'(fbit(8'h81, 1'b1, k % 11)));
      chk("R6 b2b tx plain", int'(n_tx), int'(fbit(8'h81, 1'b0, k % 10)));
      chk("R6 b2b ready par", int'(p_trdy), ((k % 11) >= 10) ? 1 : 0);
      chk("R6 b2b ready plain", int'(n_trdy), ((k % 10) >= 9) ? 1 : 0);
      tick();
    end
    send = 1'b0;
    repeat (30) tick();

    // R2: rts low drops cts, then send ignored
    rts = 1'b0;
    tick();
    chk("R2 cts drop", int'(p_cts | n_cts), 0);
    tx_data = 8'h55; send = 1'b1;
    tick();
    send = 1'b0;
    chk("R11 cts low ignored", int'(p_tx & n_tx & p_trdy & n_trdy), 1);

    // Receiver: good frame
    put_rx(8'hAA, 1'b0, 1'b0);
    chk("R7 ready par", int'(p_rrdy), 1);
    chk("R7 ready plain", int'(n_rrdy), 1);
    do_read(8'hAA, 1'b0, 1'b0);

    // R8: read while empty has no effect
    read = 1'b1;
    tick();
    read = 1'b0;
    tick();
    chk("R8 empty read data", int'(p_dat), 8'hAA);
    chk("R8 empty read err", int'(n_err), 0);

    // R9: bad parity (only parity build sees it)
    put_rx(8'h5B, 1'b1, 1'b0);
    do_read(8'h5B, 1'b1, 1'b0);

    // R9: bad stop bit
    put_rx(8'hC3, 1'b0, 1'b1);
    do_read(8'hC3, 1'b1, 1'b1);

    // R10: overrun
    put_rx(8'h12, 1'b0, 1'b0);
    put_rx(8'h34, 1'b0, 1'b0);
    chk("R10 ready held", int'(p_rrdy & n_rrdy), 1);
    do_read(8'h34, 1'b1, 1'b1);

    // Clean frame after overrun clears the flag on read
    put_rx(8'hF0, 1'b0, 1'b0);
    do_read(8'hF0, 1'b0, 1'b0);

    repeat (5) tick();
    summary();
    $finish;
  end

endmodule